// File: doc/BRIEF.md
# I2C Clock Pacer with Stretch Feedback

This block times the serial clock line of an I2C master. A programmable divider sets how many system clocks the clock line is held low and how many it stays high. The line is driven only low (open drain). After the block lets go of it, the block reads the line back through a two-flop synchronizer and an optional glitch filter. It does not start counting the high phase until that filtered copy shows a high level. A slave that holds the line low therefore lengthens the bit period by exactly as long as it holds it.

A master sequencer sits above the block. It gets single-cycle ticks that mark where to change data (a programmable number of clocks after the clock falls), where to sample (the first counted high cycle), and two set-up points inside the high phase for START and STOP edges. The sequencer presents the SDA level it wants, and the block drives SDA only on those ticks. A `run` input starts bit periods from the idle state and lets the clock park released after the current high phase. When the block is disabled or in soft reset, both lines are released and all counters are cleared.

Top module: `scl_pacer`

## Requirements
- R1: While `en` is 0 or `soft_rst` is 1, every tick output is 0. From the next clock edge on, `scl_oe` and `sda_oe` are 0 and the block is idle, so once it is enabled again with `run` at 1, `tick_sample` rises two cycles later.
- R2: With D = max(`divider`, 1) and L = `filt_len`, each low phase (`scl_oe` = 1) lasts max(D, 3 + L) cycles. The line must also be seen low through the synchronizer and filter before the low phase can end.
- R3: After release, the high phase starts 3 + L cycles after the first cycle in which `scl_in` reads 1. `tick_sample` marks that first counted cycle, so each cycle that a slave holds the line low adds one cycle.
- R4: The filter takes a new line level only after it has held for L consecutive synchronized cycles (L = 0 means synchronizer only). With L = 3, a high pulse of 2 cycles on `scl_in` during the wait does not start the high phase.
- R5: The counted high phase lasts D cycles with `scl_oe` = 0, and `tick_sample` falls in its first cycle.
- R6: With `run` held at 1, the released part of each bit period lasts 3 + L + S + D cycles, where S is the number of cycles the slave holds the line low after release.
- R7: `tick_change` fires once per low phase, at cycle index min(`sda_delay`, D - 1) counted from 0 at the first low cycle.
- R8: Inside the high phase (index 0 = `tick_sample` cycle), `tick_start` fires at index D>>1 and `tick_stop` at index (D>>1) + (D>>2).
- R9: `sda_oe` (1 = pull SDA low) changes only in the cycle after a `tick_change`, `tick_start` or `tick_stop`, and it then holds the inverse of `sda_want` as sampled at that tick.
- R10: With the block idle, raising `run` releases the line first and gives a high phase (`tick_sample` two cycles later) before any low phase. If `run` is 0 when a high phase ends, the line stays released and no further ticks come.
- R11: A `divider` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| soft_rst | input | 1 | Synchronous soft reset, releases lines and clears counters |
| run | input | 1 | Request further bit periods |
| divider | input | DIV_W | Base count of each clock phase |
| filt_len | input | FLT_W | Extra filter cycles L on the read-back clock |
| sda_delay | input | DLY_W | Data change delay after the clock falls |
| scl_in | input | 1 | Clock pin level read back |
| sda_want | input | 1 | Data level requested by the sequencer (1 = release) |
| scl_oe | output | 1 | 1 = pull the clock line low |
| sda_oe | output | 1 | 1 = pull the data line low |
| tick_change | output | 1 | Data change point in the low phase |
| tick_sample | output | 1 | First counted high cycle, the sample point |
| tick_start | output | 1 | START set-up point in the high phase |
| tick_stop | output | 1 | STOP set-up point in the high phase |

## Verification
Two pairs of functions can land in the same cycle. With a divider of 0, the sample, START and STOP ticks all fall on the single high cycle; a table row with that setting checks that all three offsets are 0 and that SDA still follows the request. With a data delay at or above the divider, the data change tick is clamped onto the last low cycle, which is also the cycle that ends the low phase. A row with delay 9 and divider 6 checks the tick at index 5 and checks that the low and released widths do not change.

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int DIV_W = 16,
  parameter int DLY_W = 8,
  parameter int FLT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             soft_rst,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  input  logic [FLT_W-1:0] filt_len,
  input  logic [DLY_W-1:0] sda_delay,
  input  logic             scl_in,
  input  logic             sda_want,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             tick_change,
  output logic             tick_sample,
  output logic             tick_start,
  output logic             tick_stop
);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_REL, S_HIGH} phase_t;

  phase_t           st;
  logic [DIV_W-1:0] cnt, dv, last, dly_x, chg_at;
  logic             hold, live;
  logic             s1, s2, flt, seen;
  logic [FLT_W-1:0] fcnt;

  assign hold   = !en || soft_rst;
  assign live   = !hold;
  assign dv     = (divider == '0) ? DIV_W'(1) : divider;
  assign last   = dv - 1'b1;
  assign dly_x  = DIV_W'(sda_delay);
  assign chg_at = (dly_x >= dv) ? last : dly_x;

  // read-back synchronizer and level filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; flt <= 1'b1; fcnt <= '0;
    end else if (hold) begin
      s1 <= 1'b1; s2 <= 1'b1; flt <= 1'b1; fcnt <= '0;
    end else begin
      s1 <= scl_in;
      s2 <= s1;
      if (s2 == flt || filt_len == '0) begin
        fcnt <= '0;
      end else if (fcnt == filt_len - 1'b1) begin
        flt  <= s2;
        fcnt <= '0;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assign seen = (filt_len == '0) ? s2 : flt;

  // phase sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (hold) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (run) st <= S_REL;
        end
        S_LOW: begin
          if (cnt >= last && !seen) begin
            st  <= S_REL;
            cnt <= '0;
          end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REL: begin
          cnt <= '0;
          if (seen) st <= S_HIGH;
        end
        default: begin
          if (cnt >= last) begin
            st  <= run ? S_LOW : S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign scl_oe      = (st == S_LOW);
  assign tick_change = live && (st == S_LOW)  && (cnt == chg_at);
  assign tick_sample = live && (st == S_HIGH) && (cnt == '0);
  assign tick_start  = live && (st == S_HIGH) && (cnt == (dv >> 1));
  assign tick_stop   = live && (st == S_HIGH) && (cnt == (dv >> 1) + (dv >> 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  sda_oe <= 1'b0;
    else if (hold)                               sda_oe <= 1'b0;
    else if (tick_change || tick_start || tick_stop) sda_oe <= !sda_want;
  end

endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             soft_rst,
  input logic [DIV_W-1:0] divider,
  input logic             scl_in,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             tick_change,
  input logic             tick_sample,
  input logic             tick_start,
  input logic             tick_stop
);

  logic [DIV_W:0]   lowc;
  logic [DIV_W-1:0] dmin;

  assign dmin = (divider == '0) ? DIV_W'(1) : divider;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowc <= '0;
    else        lowc <= scl_oe ? lowc + 1'b1 : '0;
  end

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || soft_rst) |=> (!scl_oe && !sda_oe)); // R1

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || soft_rst) |-> !(tick_change || tick_sample || tick_start || tick_stop)); // R1

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && $past(en && !soft_rst)) |-> (lowc >= {1'b0, dmin})); // R2

  AST_SAMPLE_AFTER_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample |-> $past(scl_in, 3)); // R3

  AST_SAMPLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample |-> !scl_oe); // R5

  AST_CHANGE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tick_change |-> scl_oe); // R7

  AST_SDA_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && $past(en && !soft_rst)) |-> $past(tick_change || tick_start || tick_stop)); // R9

endmodule

bind scl_pacer scl_pacer_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_scl_pacer.sv
module sim_scl_pacer;
  localparam int CLK_P = 10;
  localparam int ROWS  = 7;
  // divider, filt, sda_delay, stretch, low, released, change, start, stop
  localparam int VEC [0:ROWS-1][0:8] = '{
    '{ 8, 0, 2, 0,  8, 11, 2,  4,  6},
    '{10, 1, 0, 0, 10, 14, 0,  5,  7},
    '{ 6, 2, 9, 0,  6, 11, 5,  3,  4},
    '{12, 3, 4, 5, 12, 23, 4,  6,  9},
    '{ 4, 3, 1, 0,  6, 10, 1,  2,  3},
    '{ 0, 0, 3, 0,  3,  4, 0,  0,  0},
    '{20, 2, 7, 9, 20, 34, 7, 10, 15}
  };

  logic clk = 0, rst_n = 0, en = 0, soft_rst = 0, run = 0, want = 1;
  logic [15:0] divider = 16'd8;
  logic [1:0]  filt = 2'd0;
  logic [7:0]  sdly = 8'd0;
  logic scl_in, scl_oe, sda_oe, tick_change, tick_sample, tick_start, tick_stop;
  logic force_low = 0;
  int stretch = 0, str_left = 0, cyc = 0, errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  assign scl_in = !scl_oe && (str_left == 0) && !force_low;

  always @(posedge clk) begin
    if (scl_oe) str_left <= stretch;
    else if (str_left > 0) str_left <= str_left - 1;
  end

  scl_pacer u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .soft_rst(soft_rst), .run(run),
    .divider(divider), .filt_len(filt), .sda_delay(sdly),
    .scl_in(scl_in), .sda_want(want), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .tick_change(tick_change), .tick_sample(tick_sample),
    .tick_start(tick_start), .tick_stop(tick_stop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      wrap_up();
    end
  end

  task automatic measure(output int lo, output int chg, output int rel,
                         output int smp, output int st, output int sp);
    while (scl_oe) @(negedge clk);
    while (!scl_oe) @(negedge clk);
    lo = 0; chg = -1;
    while (scl_oe) begin
      if (tick_change && chg < 0) chg = lo;
      lo++;
      @(negedge clk);
    end
    rel = 0; smp = -1; st = -1; sp = -1;
    while (!scl_oe) begin
      if (tick_sample && smp < 0) smp = rel;
      if (tick_start && st < 0 && smp >= 0) st = rel - smp;
      if (tick_stop && sp < 0 && smp >= 0) sp = rel - smp;
      rel++;
      @(negedge clk);
    end
  endtask

  task automatic restart();
    en = 0; run = 0;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    int lo, chg, rel, smp, st, sp, k, hi, ns;
    repeat (3) @(negedge clk);
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset ticks", tick_change | tick_sample | tick_start | tick_stop, 0);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < ROWS; r++) begin
      restart();
      divider = 16'(VEC[r][0]); filt = 2'(VEC[r][1]); sdly = 8'(VEC[r][2]);
      stretch = VEC[r][3]; want = r[0];
      en = 1; run = 1;
      measure(lo, chg, rel, smp, st, sp);
      chk((r == 5) ? "R2/R11 low width" : "R2 low width", lo, VEC[r][4]);
      chk("R6 released width", rel, VEC[r][5]);
      chk("R3 sample offset", smp, 3 + VEC[r][1] + VEC[r][3]);
      chk("R7 change index", chg, VEC[r][6]);
      chk("R8 start index", st, VEC[r][7]);
      chk("R8 stop index", sp, VEC[r][8]);
      chk("R5 high length", rel - smp, (VEC[r][0] == 0) ? 1 : VEC[r][0]);
      chk("R9 sda follows want", sda_oe, !want);
    end

    // R9 timing: no change before the tick, change one cycle after it
    restart();
    divider = 16'd8; filt = 2'd0; sdly = 8'd2; stretch = 0; want = 1;
    en = 1; run = 1;
    while (scl_oe) @(negedge clk);
    while (!scl_oe) @(negedge clk);
    chk("R9 sda before request", sda_oe, 0);
    want = 0;
    @(negedge clk);
    chk("R9 sda held before tick", sda_oe, 0);
    @(negedge clk);
    chk("R7 change tick at index 2", tick_change, 1);
    @(negedge clk);
    chk("R9 sda after tick", sda_oe, 1);

    // R10: park after the current high phase, then restart from idle
    run = 0;
    while (scl_oe) @(negedge clk);
    hi = 0; ns = 0;
    repeat (60) begin
      if (scl_oe) hi++;
      if (tick_sample) ns++;
      @(negedge clk);
    end
    chk("R10 no low phase after run drop", hi, 0);
    chk("R10 one last high phase", ns, 1);
    run = 1;
    @(negedge clk);
    chk("R10 no sample one cycle after run", tick_sample, 0);
    @(negedge clk);
    chk("R10 sample two cycles after run", tick_sample, 1);
    chk("R10 line released at start", scl_oe, 0);

    // R4: a short high pulse is filtered out, a steady release is timed
    restart();
    divider = 16'd8; filt = 2'd3; sdly = 8'd1; stretch = 0;
    en = 1; run = 1;
    while (!scl_oe) @(negedge clk);
    force_low = 1;
    while (scl_oe) @(negedge clk);
    repeat (6) @(negedge clk);
    force_low = 0;
    repeat (2) @(negedge clk);
    force_low = 1;
    ns = 0;
    repeat (12) begin
      if (tick_sample) ns++;
      @(negedge clk);
    end
    chk("R4 glitch ignored", ns, 0);
    chk("R4 still released", scl_oe, 0);
    force_low = 0;
    k = 0;
    while (!tick_sample && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk("R3/R4 sample after filtered release", k, 6);

    // R1: soft reset mid low phase
    while (!scl_oe) @(negedge clk);
    @(negedge clk);
    soft_rst = 1;
    @(negedge clk);
    chk("R1 soft reset scl_oe", scl_oe, 0);
    chk("R1 soft reset sda_oe", sda_oe, 0);
    hi = 0; ns = 0;
    repeat (5) begin
      if (scl_oe) hi++;
      if (tick_change | tick_sample | tick_start | tick_stop) ns++;
      @(negedge clk);
    end
    chk("R1 held released", hi, 0);
    chk("R1 no ticks in soft reset", ns, 0);
    soft_rst = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 restart from idle", tick_sample, 1);

    wrap_up();
  end
endmodule